// File: doc/BRIEF.md
# I2C Control Register Bank for an Audio Processor

This block is a write-only I2C target that holds the eight control bytes of an audio signal path. The controller bus lines SCL and SDA are brought into the system clock domain through two-flop synchronizers. The block then detects START and STOP conditions, shifts in bytes MSB first and acknowledges the bytes it accepts. It drives SDA by pulling it low only, and releases it otherwise.

A transfer carries three kinds of byte in order:
- an address byte, which must match the fixed device address and select a write;
- a subaddress byte, which picks the starting register and can turn on auto-increment;
- any number of data bytes, which are stored in the register bank.

The stored bytes appear at the outputs as a mode byte, a left and a right input gain code, and four high-pass filter codes. Two mute outputs each combine one mode bit with an active-low external mute pin.

Top module: `i2c_ctrl_regs`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address reception at any point, including in the middle of a byte, and the partial byte is discarded. A STOP (SDA rising while SCL is high) returns the block to idle.
- R2: An address byte whose upper seven bits are 1000101 and whose LSB (R/W) is 0 is acknowledged. During the ninth clock the block pulls SDA low.
- R3: An address byte with other upper bits, or with R/W = 1, is not acknowledged. Every byte after it is also not acknowledged and leaves the registers unchanged, until the next START.
- R4: The byte after an accepted address is the subaddress. Bits 2..0 give the register index, bit 4 enables auto-increment, and bits 7..5 and 3 are ignored. The subaddress byte is acknowledged.
- R5: Register index 1 drives `mode`, 2 drives `gain_l`, 3 drives `gain_r`, and 4, 5, 6 and 7 drive `hp_fl`, `hp_fr`, `hp_rl` and `hp_rr`.
- R6: With auto-increment enabled, each data byte is acknowledged and written to the current index, and the index then advances by one, wrapping from 7 to 0. A data byte aimed at index 0 is acknowledged and discarded.
- R7: With auto-increment disabled, every data byte of the transfer rewrites the same register.
- R8: `hp_mute` is high when `mode` bit 0 is 1 or `mute_n` is low. `aux_mute` is high when `mode` bit 1 is 1 or `mute_n` is low.
- R9: After reset all registers read 0x00 and SDA is released.
- R10: SDA is pulled low only for the acknowledge. The pull starts after the SCL falling edge that ends the eighth bit and stops after the SCL falling edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| mute_n | input | 1 | External mute, active low |
| mode | output | 8 | Mode register (index 1) |
| gain_l | output | 8 | Left input gain code (index 2) |
| gain_r | output | 8 | Right input gain code (index 3) |
| hp_fl | output | 8 | Front-left high-pass code (index 4) |
| hp_fr | output | 8 | Front-right high-pass code (index 5) |
| hp_rl | output | 8 | Rear-left high-pass code (index 6) |
| hp_rr | output | 8 | Rear-right high-pass code (index 7) |
| hp_mute | output | 1 | Combined high-pass mute |
| aux_mute | output | 1 | Combined input mute |

## Verification
The write path is tried with four kinds of transfer:
- Single-register writes with auto-increment off separate a pointer that stays put from one that drifts.
- Bursts that start at index 2 and at index 7 expose a wrong increment, a missing wrap to 0 and a write that leaks into index 0.
- Subaddress bytes with their unused bits set show whether those bits reach the index or the increment flag.
- A foreign address, a read request, bytes sent after a STOP and a START in the middle of a byte each check that no register changes and no acknowledge is given.

Throughout, the mute pin is toggled against both mode mute bits.

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs #(
  parameter logic [6:0] DEV_ADDR = 7'b1000101,
  parameter int NREG     = 8,
  parameter int HPM_BIT  = 0,
  parameter int AUXM_BIT = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  input  logic       mute_n,
  output logic [7:0] mode,
  output logic [7:0] gain_l,
  output logic [7:0] gain_r,
  output logic [7:0] hp_fl,
  output logic [7:0] hp_fr,
  output logic [7:0] hp_rl,
  output logic [7:0] hp_rr,
  output logic       hp_mute,
  output logic       aux_mute
);
  localparam int IW = $clog2(NREG);

  typedef enum logic [1:0] {IDLE, ADDR, SUB, DATA} st_t;

  st_t           state;
  logic [2:0]    scl_q, sda_q;
  logic [7:0]    shreg;
  logic [3:0]    bitcnt;
  logic          in_ack, ack_req, ainc;
  logic [IW-1:0] ptr;
  logic [7:0]    regs [NREG];

  wire scl_s    = scl_q[1];
  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start_c  = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_c   = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire [7:0] byte_in = {shreg[6:0], sda_q[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      in_ack   <= 1'b0;
      ack_req  <= 1'b0;
      ainc     <= 1'b0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (start_c) begin
      state    <= ADDR;
      bitcnt   <= '0;
      in_ack   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_c) begin
      state    <= IDLE;
      in_ack   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (state != IDLE) begin
      if (scl_rise && bitcnt != 4'd8) begin
        shreg  <= byte_in;
        bitcnt <= bitcnt + 4'd1;
        if (bitcnt == 4'd7) begin
          unique case (state)
            ADDR: begin
              if (byte_in[7:1] == DEV_ADDR && !byte_in[0]) begin
                ack_req <= 1'b1;
                state   <= SUB;
              end else begin
                ack_req <= 1'b0;
                state   <= IDLE;
              end
            end
            SUB: begin
              ptr     <= byte_in[IW-1:0];
              ainc    <= byte_in[4];
              ack_req <= 1'b1;
              state   <= DATA;
            end
            default: begin
              if (ptr != '0) regs[ptr] <= byte_in;
              if (ainc) ptr <= ptr + 1'b1;
              ack_req <= 1'b1;
            end
          endcase
        end
      end
      if (scl_fall && bitcnt == 4'd8) begin
        if (!in_ack) begin
          in_ack   <= 1'b1;
          sda_pull <= ack_req;
        end else begin
          in_ack   <= 1'b0;
          sda_pull <= 1'b0;
          bitcnt   <= '0;
        end
      end
    end
  end

  assign mode     = regs[1];
  assign gain_l   = regs[2];
  assign gain_r   = regs[3];
  assign hp_fl    = regs[4];
  assign hp_fr    = regs[5];
  assign hp_rl    = regs[6];
  assign hp_rr    = regs[7];
  assign hp_mute  = ~mute_n | regs[1][HPM_BIT];
  assign aux_mute = ~mute_n | regs[1][AUXM_BIT];

  logic unused_ok;
  assign unused_ok = scl_s;
endmodule

// File: rtl/i2c_ctrl_regs_chk.sv
module i2c_ctrl_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       sda_pull,
  input logic       idle,
  input logic       in_data,
  input logic [3:0] bitcnt,
  input logic       mute_n,
  input logic       hpm_bit,
  input logic       auxm_bit,
  input logic       hp_mute,
  input logic       aux_mute,
  input logic [55:0] bank
);
  AST_PULL_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_s);                                    // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    idle |-> !sda_pull);                                            // R3
  AST_WRITE_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    !$stable(bank) |-> $past(in_data));                             // R6
  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= 4'd8);                                                // R1
  AST_PIN_MUTES: assert property (@(posedge clk) disable iff (rst)
    !mute_n |-> (hp_mute && aux_mute));                             // R8
  AST_HP_MUTE_BIT: assert property (@(posedge clk) disable iff (rst)
    hpm_bit |-> hp_mute);                                           // R8
  AST_AUX_MUTE_BIT: assert property (@(posedge clk) disable iff (rst)
    auxm_bit |-> aux_mute);                                         // R8
endmodule

bind i2c_ctrl_regs i2c_ctrl_regs_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_q[1]), .sda_pull(sda_pull),
  .idle(state == IDLE), .in_data(state == DATA), .bitcnt(bitcnt),
  .mute_n(mute_n), .hpm_bit(mode[HPM_BIT]), .auxm_bit(mode[AUXM_BIT]),
  .hp_mute(hp_mute), .aux_mute(aux_mute),
  .bank({mode, gain_l, gain_r, hp_fl, hp_fr, hp_rl, hp_rr})
);

// File: tb/i2c_ctrl_regs_test.sv
module i2c_ctrl_regs_test;
  logic clk = 0, rst = 1;
  logic scl_m = 1, sda_m = 1, mute_n = 1;
  logic sda_pull, hp_mute, aux_mute;
  logic [7:0] mode, gain_l, gain_r, hp_fl, hp_fr, hp_rl, hp_rr;
  wire sda_bus = sda_m & ~sda_pull;

  always #2 clk = ~clk;

  i2c_ctrl_regs uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_pull(sda_pull),
    .mute_n(mute_n), .mode(mode), .gain_l(gain_l), .gain_r(gain_r),
    .hp_fl(hp_fl), .hp_fr(hp_fr), .hp_rl(hp_rl), .hp_rr(hp_rr),
    .hp_mute(hp_mute), .aux_mute(aux_mute));

  localparam int H = 10;
  int total = 0, bad = 0;
  bit finished = 0, cmp_en = 0;
  logic [7:0] exp_r [8];
  int m_st = 0;
  int m_ptr = 0;
  bit m_inc = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      check({mode, gain_l, gain_r, hp_fl, hp_fr, hp_rl, hp_rr} ==
            {exp_r[1], exp_r[2], exp_r[3], exp_r[4], exp_r[5], exp_r[6], exp_r[7]},
            "R5 register outputs",
            {8'h0, mode, gain_l, gain_r, hp_fl, hp_fr, hp_rl, hp_rr},
            {8'h0, exp_r[1], exp_r[2], exp_r[3], exp_r[4], exp_r[5], exp_r[6], exp_r[7]});
      check({hp_mute, aux_mute} == {~mute_n | exp_r[1][0], ~mute_n | exp_r[1][1]},
            "R8 mute outputs", {hp_mute, aux_mute}, {~mute_n | exp_r[1][0], ~mute_n | exp_r[1][1]});
    end
  end

  task automatic model(input logic [7:0] b, output bit ack, output string tag);
    case (m_st)
      1: begin
        if (b[7:1] == 7'b1000101 && b[0] == 1'b0) begin ack = 1; m_st = 2; tag = "R2 address ack"; end
        else begin ack = 0; m_st = 0; tag = "R3 address nack"; end
      end
      2: begin
        m_ptr = b[2:0]; m_inc = b[4]; m_st = 3; ack = 1; tag = "R4 subaddress ack";
      end
      3: begin
        if (m_ptr != 0) exp_r[m_ptr] = b;
        tag = m_inc ? "R6 data ack" : "R7 data ack";
        if (m_inc) m_ptr = (m_ptr + 1) % 8;
        ack = 1;
      end
      default: begin ack = 0; tag = "R3 ignored byte"; end
    endcase
  endtask

  task automatic i2c_start;
    sda_m = 1; tick(H); scl_m = 1; tick(H);
    sda_m = 0; tick(H); scl_m = 0; tick(H);
    m_st = 1;
  endtask

  task automatic i2c_stop;
    sda_m = 0; tick(H); scl_m = 1; tick(H); sda_m = 1; tick(H);
    m_st = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit got, expa;
    string tag;
    cmp_en = 0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H); scl_m = 1; tick(H / 2);
      check(sda_pull == 1'b0, "R10 no pull during data bit", sda_pull, 0);
      tick(H / 2); scl_m = 0; tick(2);
    end
    sda_m = 1; tick(H);
    scl_m = 1; tick(H / 2);
    got = !sda_bus;
    tick(H / 2); scl_m = 0; tick(6);
    check(sda_pull == 1'b0, "R10 pull released after ninth clock", sda_pull, 0);
    model(b, expa, tag);
    check(got == expa, tag, got, expa);
    tick(H);
    cmp_en = 1;
  endtask

  task automatic start_mid_byte(input logic [2:0] bits);
    cmp_en = 0;
    for (int i = 2; i >= 0; i--) begin
      sda_m = bits[i]; tick(H); scl_m = 1; tick(H); scl_m = 0; tick(2);
    end
    sda_m = 1; tick(H); scl_m = 1; tick(H);
    sda_m = 0; tick(H); scl_m = 0; tick(H);
    m_st = 1;
    cmp_en = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) exp_r[k] = 8'h00;
    tick(5); rst = 0; tick(5);
    check({mode, gain_l, gain_r, hp_fl, hp_fr, hp_rl, hp_rr, sda_pull} == '0,
          "R9 reset state", {mode, gain_l, gain_r, hp_fl, hp_fr, hp_rl, hp_rr}, 0);
    cmp_en = 1;

    // R7 single write, R5 mode
    i2c_start; send_byte(8'h8A); send_byte(8'h01); send_byte(8'h40); i2c_stop;
    // R6 burst from index 2
    i2c_start; send_byte(8'h8A); send_byte(8'h12);
    send_byte(8'h9C); send_byte(8'h3E); send_byte(8'h05); send_byte(8'h16); send_byte(8'hA7);
    i2c_stop;
    // R6 wrap 7 -> 0 (discarded) -> 1
    i2c_start; send_byte(8'h8A); send_byte(8'h17);
    send_byte(8'h7B); send_byte(8'hEE); send_byte(8'h01); i2c_stop;
    // R7 repeated rewrite of index 4
    i2c_start; send_byte(8'h8A); send_byte(8'h04);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h0C); i2c_stop;
    // R4 ignored bits: 0xE9 -> idx1 no inc, 0xFB -> idx3 inc
    i2c_start; send_byte(8'h8A); send_byte(8'hE9); send_byte(8'h02); send_byte(8'h03); i2c_stop;
    i2c_start; send_byte(8'h8A); send_byte(8'hFB); send_byte(8'h5A); send_byte(8'h66); i2c_stop;
    // R6 index 0 only
    i2c_start; send_byte(8'h8A); send_byte(8'h00); send_byte(8'hFF); i2c_stop;
    // R3 foreign address and read request
    i2c_start; send_byte(8'h8C); send_byte(8'h02); send_byte(8'h99); i2c_stop;
    i2c_start; send_byte(8'h8B); send_byte(8'h03); send_byte(8'h77); i2c_stop;
    // R3 bytes after STOP without START
    send_byte(8'h8A); send_byte(8'h02);
    // R1 START in the middle of a byte aborts
    i2c_start; send_byte(8'h8A); send_byte(8'h05);
    start_mid_byte(3'b101);
    send_byte(8'h8A); send_byte(8'h06); send_byte(8'h3C); i2c_stop;
    // R8 mute pin against mode bits
    i2c_start; send_byte(8'h8A); send_byte(8'h01); send_byte(8'h00); i2c_stop;
    mute_n = 0; tick(4);
    check({hp_mute, aux_mute} == 2'b11, "R8 pin forces mute", {hp_mute, aux_mute}, 2'b11);
    mute_n = 1; tick(4);
    check({hp_mute, aux_mute} == 2'b00, "R8 mute released", {hp_mute, aux_mute}, 2'b00);
    i2c_start; send_byte(8'h8A); send_byte(8'h01); send_byte(8'h01); i2c_stop;
    check({hp_mute, aux_mute} == 2'b10, "R8 mode bit 0 only", {hp_mute, aux_mute}, 2'b10);

    tick(10);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule